// File: doc/BRIEF.md
# Satellite Dish Tone Message Controller

The block sends short command messages to an outdoor satellite unit (low-noise block converter, dish positioner, switch) by keying a 22 kHz carrier on and off. It also captures the unit's tone-keyed reply into a small buffer for the host. The host loads up to eight command bytes and writes a control byte holding a byte count and a start bit. The block then plays the message out. Each bit is a burst of carrier followed by silence, and its value is set by which part is longer. Every byte goes out most significant bit first, followed by an odd parity bit.

The same control byte also sets two things that hold between messages: a polarisation select level and a continuous-carrier enable. The continuous carrier is muted while a message is on the line. On the receive side, the tone arrives already reduced to a digital presence level. Bursts shorter than one and a half slots are read as ones and longer bursts as zeros. A long silence ends the reply. The host then reads the status, the stored bytes and a per-byte parity error mask.

The unit of time is a slot: `2*HALF_CYC*PER_SLOT` clock cycles, which is nominally 0.5 ms. One bit takes three slots.

Top module: `tone_msg_ctrl`

## Requirements
- R1: After reset, tone_out, tone_env and pol_out are 0, and reads of address 8 (status) and address 9 (parity mask) return 0.
- R2: While a message is sent, a zero bit puts tone_env high for two slots and then low for one slot. A one bit puts it high for one slot and then low for two slots. tone_env goes high at the first clock edge after the accepted start write.
- R3: Bytes go out from address 0 upward. Within each byte the bits go out from bit 7 down to bit 0, followed by a parity bit that makes the number of ones in the nine bits odd.
- R4: A write to address 8 with bit 4 (start) set uses bits [3:0] as the byte count. A count of 1 to 8 sends that many bytes, a count of 9 to 15 sends 8 bytes, and a count of 0 starts nothing. Status bit 7 (busy) stays high for exactly count×27 slots.
- R5: A start write while a message is being sent has no effect on that message.
- R6: tone_out carries the free-running carrier (period 2*HALF_CYC cycles) while tone_env is high. It also carries the carrier while the continuous enable (control bit 6) is set and no message is active. At all other times tone_out is 0.
- R7: pol_out follows control bit 5 from the clock edge of the write onward.
- R8: A received burst shorter than 1.5 slots is read as 1, and a longer one as 0. Nine bursts form one byte, with the first bit as bit 7 and the ninth as parity. Stored bytes are read at addresses 0 up to 7 in arrival order, and status bits [3:0] give their number.
- R9: Bit i of the parity mask at address 9 is set when the nine bits received for byte i hold an even number of ones.
- R10: A silence longer than END_SLOTS slots after at least one burst sets status bit 6 (reply complete) and drops any incomplete byte. Bursts that arrive afterward are ignored until the receiver is re-armed.
- R11: At most eight bytes are stored. Later bytes are dropped, and the count stays at 8.
- R12: The receiver ignores its input while a message is being sent. An accepted start, or a control write with bit 7 set while idle, clears the stored count, bytes, parity mask and the complete flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| rx_tone | input | 1 | Digital tone-presence level from the reply detector |
| tone_out | output | 1 | Keyed or continuous 22 kHz carrier |
| tone_env | output | 1 | Keying envelope of the message being sent |
| pol_out | output | 1 | Polarisation select level |

## Verification
A wrong slot, bit or byte counter in the sender moves an edge of tone_env. The bench's cycle model compares that envelope on every clock, so the error shows up within one slot of the miscount. A miscounted bit only appears when the model expects the other keying pattern. A wrong parity or bit order shows within the first byte whose value exposes it. Faults in the receiver stay hidden until the silence timeout, when status, stored bytes and the parity mask are read back. The reply patterns therefore mix both bit values, one corrupted parity bit, a trailing partial byte and an overlong reply.

// File: rtl/tone_msg_pkg.sv
package tone_msg_pkg;
    localparam int MAX_BYTES   = 8;
    localparam int IDX_W       = $clog2(MAX_BYTES);
    localparam int CNT_W       = IDX_W + 1;
    localparam int BUF_W       = MAX_BYTES * 8;
    localparam int CHAR_BITS   = 9;
    localparam logic [3:0] A_CTRL = 4'd8;
    localparam logic [3:0] A_PERR = 4'd9;

    typedef struct packed {
        logic       rearm;
        logic       cont;
        logic       pol;
        logic       start;
        logic [3:0] count;
    } ctrl_t;

    function automatic logic odd_par(input logic [7:0] b);
        return ~^b;
    endfunction

    function automatic logic [3:0] clamp_count(input logic [3:0] c);
        return (c > 4'(MAX_BYTES)) ? 4'(MAX_BYTES) : c;
    endfunction
endpackage

// File: rtl/tone_carrier.sv
module tone_carrier #(
    parameter int HALF_CYC = 2
) (
    input  logic clk,
    input  logic rst,
    output logic carrier
);
    localparam int HW = $clog2(HALF_CYC + 1);
    localparam logic [HW-1:0] LAST = HW'(HALF_CYC - 1);
    logic [HW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            carrier <= 1'b0;
        end else if (cnt == LAST) begin
            cnt     <= '0;
            carrier <= ~carrier;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/tone_tx.sv
module tone_tx
    import tone_msg_pkg::*;
#(
    parameter int SLOT_CYC = 44
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [3:0]       count,
    input  logic [BUF_W-1:0] tx_buf,
    output logic             busy,
    output logic             env
);
    localparam int SW = $clog2(SLOT_CYC + 1);
    localparam logic [SW-1:0] CYC_LAST = SW'(SLOT_CYC - 1);

    logic [SW-1:0]    cyc;
    logic [1:0]       slot;
    logic [3:0]       bit_idx;
    logic [IDX_W-1:0] byte_idx, last_byte;
    logic [7:0]       cur_byte;
    logic             bit_val;

    assign cur_byte = tx_buf[{byte_idx, 3'b000} +: 8];
    assign bit_val  = (bit_idx == 4'(CHAR_BITS - 1)) ? odd_par(cur_byte)
                                                     : cur_byte[3'd7 - bit_idx[2:0]];
    assign env      = busy && (slot == 2'd0 || (slot == 2'd1 && !bit_val));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            cyc       <= '0;
            slot      <= '0;
            bit_idx   <= '0;
            byte_idx  <= '0;
            last_byte <= '0;
        end else if (!busy) begin
            if (start) begin
                busy      <= 1'b1;
                cyc       <= '0;
                slot      <= '0;
                bit_idx   <= '0;
                byte_idx  <= '0;
                last_byte <= IDX_W'(count - 4'd1);
            end
        end else if (cyc != CYC_LAST) begin
            cyc <= cyc + 1'b1;
        end else begin
            cyc <= '0;
            if (slot != 2'd2) begin
                slot <= slot + 1'b1;
            end else begin
                slot <= '0;
                if (bit_idx != 4'(CHAR_BITS - 1)) begin
                    bit_idx <= bit_idx + 1'b1;
                end else begin
                    bit_idx <= '0;
                    if (byte_idx == last_byte) busy <= 1'b0;
                    else                       byte_idx <= byte_idx + 1'b1;
                end
            end
        end
    end

    p_index_bound_r3: assert property (@(posedge clk) disable iff (rst)
        busy |-> (bit_idx <= 4'(CHAR_BITS - 1) && byte_idx <= last_byte));
    p_end_on_last_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> ($past(byte_idx) == $past(last_byte) && $past(bit_idx) == 4'(CHAR_BITS - 1)));
    p_restart_ignored_r5: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> (busy || $past(cyc) == CYC_LAST) && $stable(last_byte));
endmodule

// File: rtl/tone_rx.sv
module tone_rx
    import tone_msg_pkg::*;
#(
    parameter int SLOT_CYC  = 44,
    parameter int END_SLOTS = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tone_in,
    input  logic             hold,
    input  logic             clr,
    output logic [BUF_W-1:0] rx_buf,
    output logic [CNT_W-1:0] rx_count,
    output logic [MAX_BYTES-1:0] rx_perr,
    output logic             rx_done
);
    localparam int THR = (SLOT_CYC * 3) / 2;
    localparam int SIL = SLOT_CYC * END_SLOTS;
    localparam int RW  = $clog2(SIL + 1);

    logic          s1, s2, prev, seen;
    logic [RW-1:0] run;
    logic [7:0]    shreg;
    logic [3:0]    bitcnt;
    logic          fall, new_bit, listen;

    assign fall    = prev && !s2;
    assign new_bit = run < RW'(THR);
    assign listen  = !hold && !rx_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            {s1, s2, prev, seen} <= '0;
            run      <= '0;
            shreg    <= '0;
            bitcnt   <= '0;
            rx_buf   <= '0;
            rx_count <= '0;
            rx_perr  <= '0;
            rx_done  <= 1'b0;
        end else begin
            s1   <= tone_in;
            s2   <= s1;
            prev <= s2;
            if (s2 != prev)           run <= '0;
            else if (run != RW'(SIL)) run <= run + 1'b1;

            if (clr) begin
                rx_buf   <= '0;
                rx_count <= '0;
                rx_perr  <= '0;
                rx_done  <= 1'b0;
                bitcnt   <= '0;
                seen     <= 1'b0;
            end else if (listen) begin
                if (fall) begin
                    seen <= 1'b1;
                    if (bitcnt == 4'(CHAR_BITS - 1)) begin
                        bitcnt <= '0;
                        if (rx_count < CNT_W'(MAX_BYTES)) begin
                            rx_buf[{rx_count[IDX_W-1:0], 3'b000} +: 8] <= shreg;
                            rx_perr[rx_count[IDX_W-1:0]] <= ~^{shreg, new_bit};
                            rx_count <= rx_count + 1'b1;
                        end
                    end else begin
                        shreg  <= {shreg[6:0], new_bit};
                        bitcnt <= bitcnt + 1'b1;
                    end
                end else if (!s2 && seen && run == RW'(SIL)) begin
                    rx_done <= 1'b1;
                    bitcnt  <= '0;
                end
            end else if (hold) begin
                bitcnt <= '0;
                seen   <= 1'b0;
            end
        end
    end

    p_perr_in_range_r9: assert property (@(posedge clk) disable iff (rst)
        (rx_perr >> rx_count) == '0);
    p_done_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        (rx_done && !clr) |=> rx_done);
    p_count_cap_r11: assert property (@(posedge clk) disable iff (rst)
        rx_count <= CNT_W'(MAX_BYTES));
    p_hold_frozen_r12: assert property (@(posedge clk) disable iff (rst)
        (hold && !clr) |=> $stable(rx_count));
endmodule

// File: rtl/tone_msg_ctrl.sv
module tone_msg_ctrl
    import tone_msg_pkg::*;
#(
    parameter int HALF_CYC  = 2,
    parameter int PER_SLOT  = 11,
    parameter int END_SLOTS = 12
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] bus_addr,
    input  logic       bus_wr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       rx_tone,
    output logic       tone_out,
    output logic       tone_env,
    output logic       pol_out
);
    localparam int SLOT_CYC = 2 * HALF_CYC * PER_SLOT;

    ctrl_t              wr_ctrl;
    logic               ctrl_wr, start_req, tx_busy, carrier, cont_q, rx_clr;
    logic [BUF_W-1:0]   tx_buf, rx_buf;
    logic [CNT_W-1:0]   rx_count;
    logic [MAX_BYTES-1:0] rx_perr;
    logic               rx_done;

    assign wr_ctrl   = ctrl_t'(bus_wdata);
    assign ctrl_wr   = bus_wr && bus_addr == A_CTRL;
    assign start_req = ctrl_wr && wr_ctrl.start && wr_ctrl.count != 4'd0;
    assign rx_clr    = !tx_busy && (start_req || (ctrl_wr && wr_ctrl.rearm));

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_buf  <= '0;
            cont_q  <= 1'b0;
            pol_out <= 1'b0;
        end else if (bus_wr) begin
            if (bus_addr < 4'(MAX_BYTES))
                tx_buf[{bus_addr[IDX_W-1:0], 3'b000} +: 8] <= bus_wdata;
            else if (bus_addr == A_CTRL) begin
                cont_q  <= wr_ctrl.cont;
                pol_out <= wr_ctrl.pol;
            end
        end
    end

    tone_carrier #(.HALF_CYC(HALF_CYC)) u_carrier (
        .clk(clk), .rst(rst), .carrier(carrier)
    );

    tone_tx #(.SLOT_CYC(SLOT_CYC)) u_tx (
        .clk(clk), .rst(rst), .start(start_req),
        .count(clamp_count(wr_ctrl.count)), .tx_buf(tx_buf),
        .busy(tx_busy), .env(tone_env)
    );

    tone_rx #(.SLOT_CYC(SLOT_CYC), .END_SLOTS(END_SLOTS)) u_rx (
        .clk(clk), .rst(rst), .tone_in(rx_tone), .hold(tx_busy), .clr(rx_clr),
        .rx_buf(rx_buf), .rx_count(rx_count), .rx_perr(rx_perr), .rx_done(rx_done)
    );

    assign tone_out = carrier && (tone_env || (cont_q && !tx_busy));

    always_comb begin
        bus_rdata = '0;
        if (bus_addr < 4'(MAX_BYTES))
            bus_rdata = rx_buf[{bus_addr[IDX_W-1:0], 3'b000} +: 8];
        else if (bus_addr == A_CTRL)
            bus_rdata = {tx_busy, rx_done, 2'b00, 4'(rx_count)};
        else if (bus_addr == A_PERR)
            bus_rdata = 8'(rx_perr);
    end

    p_quiet_idle_r6: assert property (@(posedge clk) disable iff (rst)
        (!tx_busy && !cont_q) |-> !tone_out);
    p_muted_gap_r6: assert property (@(posedge clk) disable iff (rst)
        (tx_busy && !tone_env) |-> !tone_out);
    p_pol_follow_r7: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr |=> pol_out == $past(bus_wdata[5]));
endmodule

// File: tb/tone_msg_ctrl_bench.sv
module tone_msg_ctrl_bench;
    localparam int HALF = 2, PER = 11, ENDS = 12;
    localparam int S = 2 * HALF * PER;

    logic clk = 0, rst = 1;
    logic [3:0] bus_addr = 0;
    logic bus_wr = 0;
    logic [7:0] bus_wdata = 0;
    logic [7:0] bus_rdata;
    logic rx_tone = 0;
    logic tone_out, tone_env, pol_out;

    int checks = 0, errors = 0;

    tone_msg_ctrl #(.HALF_CYC(HALF), .PER_SLOT(PER), .END_SLOTS(ENDS)) u_tone_msg_ctrl (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .rx_tone(rx_tone), .tone_out(tone_out),
        .tone_env(tone_env), .pol_out(pol_out)
    );

    always #5 clk = ~clk;

    // reference model state
    logic [7:0] txq [8];
    logic [7:0] m_bytes [8];
    bit m_active = 0, m_cont = 0, m_pol = 0;
    int m_t = 0, m_n = 0;
    int rises = 0;
    bit last_out = 0;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit exp_env();
        int bn, sl, by, pos;
        bit v;
        if (!m_active) return 0;
        bn = m_t / (3 * S); sl = (m_t % (3 * S)) / S;
        by = bn / 9; pos = bn % 9;
        v = (pos == 8) ? ~^m_bytes[by] : m_bytes[by][7 - pos];
        return (sl == 0) || (sl == 1 && !v);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_active = 0; m_t = 0; m_cont = 0; m_pol = 0;
        end else begin
            if (m_active) begin
                if (m_t == m_n * 27 * S - 1) m_active = 0;
                else m_t++;
            end else if (bus_wr && bus_addr == 8 && bus_wdata[4] && bus_wdata[3:0] != 0) begin
                m_active = 1; m_t = 0;
                m_n = (bus_wdata[3:0] > 8) ? 8 : int'(bus_wdata[3:0]);
                for (int i = 0; i < 8; i++) m_bytes[i] = txq[i];
            end
            if (bus_wr && bus_addr == 8) begin
                m_cont = bus_wdata[6]; m_pol = bus_wdata[5];
            end
        end
    end

    // per-cycle comparison: R2, R3, R4, R5 through the envelope; R6 and R7 at the pins
    always @(negedge clk) begin
        if (!rst) begin
            chk("R2/R3 envelope", tone_env, exp_env());
            if (!exp_env() && !(m_cont && !m_active)) chk("R6 carrier muted", tone_out, 0);
            chk("R7 polarisation", pol_out, m_pol);
            if (tone_out && !last_out) rises++;
            last_out = tone_out;
        end
    end

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1;
        if (a < 8) txq[a] = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic wait_idle();
        while (m_active) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic rx_bit(input bit b);
        @(negedge clk); rx_tone = 1;
        repeat (b ? S : 2 * S) @(negedge clk);
        rx_tone = 0;
        repeat (b ? 2 * S - 1 : S - 1) @(negedge clk);
    endtask

    task automatic rx_byte(input logic [7:0] b, input bit bad);
        for (int i = 7; i >= 0; i--) rx_bit(b[i]);
        rx_bit(~^b ^ bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        for (int i = 0; i < 8; i++) txq[i] = 0;
        repeat (4) @(negedge clk);
        rst = 0;
        // R1 reset state
        chk("R1 tone_out", tone_out, 0);
        chk("R1 tone_env", tone_env, 0);
        chk("R1 pol_out", pol_out, 0);
        rd(8, v); chk("R1 status", v, 0);
        rd(9, v); chk("R1 parity mask", v, 0);

        // R6/R7 continuous carrier idle, polarisation
        wr(8, 8'h60);
        rises = 0;
        repeat (20) @(negedge clk);
        chk("R6 continuous carrier present", int'(rises > 0), 1);

        // R2/R3 three-byte message, continuous enabled (muted during message)
        wr(0, 8'hE2); wr(1, 8'h10); wr(2, 8'h00);
        wr(8, 8'h73);
        rises = 0;
        repeat (200) @(negedge clk);
        wr(8, 8'h71);                       // R5 start while busy
        rd(8, v); chk("R5 still busy", v[7], 1);
        wait_idle();
        chk("R6 carrier during bursts", int'(rises > 0), 1);
        rd(8, v); chk("R4 busy cleared", v[7], 0);

        // R4 count zero starts nothing
        wr(8, 8'h10);
        repeat (3) @(negedge clk);
        rd(8, v); chk("R4 zero count idle", v[7], 0);
        chk("R4 zero count no envelope", tone_env, 0);

        // R4 count above eight clamps to eight
        for (int i = 0; i < 8; i++) wr(4'(i), 8'(i * 29 + 3));
        wr(8, 8'h1C);
        repeat (8 * 27 * S - 10) @(negedge clk);
        rd(8, v); chk("R4 busy through eighth byte", v[7], 1);
        wait_idle();
        rd(8, v); chk("R4 busy ends after eight bytes", v[7], 0);

        // R8/R9/R10 reply with a bad parity byte and a trailing partial byte
        rx_byte(8'hE4, 0); rx_byte(8'h5A, 1); rx_byte(8'h01, 0);
        for (int i = 0; i < 4; i++) rx_bit(1);
        repeat ((ENDS + 3) * S) @(negedge clk);
        rd(8, v); chk("R10 complete flag", v[6], 1);
        chk("R8/R10 byte count", v[3:0], 3);
        rd(0, v); chk("R8 byte0", v, 8'hE4);
        rd(1, v); chk("R8 byte1", v, 8'h5A);
        rd(2, v); chk("R8 byte2", v, 8'h01);
        rd(9, v); chk("R9 parity mask", v, 8'h02);

        // R12 start clears, input ignored during message
        wr(0, 8'hA5); wr(8, 8'h11);
        rd(8, v); chk("R12 cleared count", v[3:0], 0);
        chk("R12 cleared flag", v[6], 0);
        for (int i = 0; i < 4; i++) rx_bit(0);
        wait_idle();
        rd(8, v); chk("R12 ignored during message", v, 0);

        // R11 overlong reply
        for (int i = 0; i < 10; i++) rx_byte(8'(i * 17 + 5), 0);
        repeat ((ENDS + 3) * S) @(negedge clk);
        rd(8, v); chk("R11 count capped", v[3:0], 8);
        chk("R11 complete", v[6], 1);
        for (int i = 0; i < 8; i++) begin
            rd(4'(i), v); chk("R11 stored byte", v, 8'(i * 17 + 5));
        end
        rd(9, v); chk("R9 clean mask", v, 0);

        // R10 bursts after completion ignored
        rx_byte(8'hFF, 0);
        repeat (10) @(negedge clk);
        rd(0, v); chk("R10 byte0 unchanged", v, 8'h05);
        rd(8, v); chk("R10 count unchanged", v[3:0], 8);

        // R12 rearm without sending
        wr(8, 8'h80);
        rd(8, v); chk("R12 rearm clears", v, 0);
        rd(9, v); chk("R12 rearm mask", v, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule